// File: doc/BRIEF.md
# Multi-Map I2C Register Target

This block is an I2C target for a display transmitter. It answers on one fixed device address and on three device addresses that software can move. Each address opens its own 256-byte register store. Map 0 is the main map. Map 1 holds packet data, map 2 holds sink data and map 3 holds control messages. The main map holds the three movable addresses, a power-down bit, a hot-plug status bit, an interrupt enable byte and a byte of write-one-to-clear interrupt flags. An active-high interrupt output follows the enabled flags.

SCL and SDA pass through a two-flop synchronizer. START and STOP are found by watching SDA change while SCL is high. The system clock must run at least eight times faster than the bus.

The bus engine is a state machine with these states:

- ST_IDLE waits for a START.
- ST_ADDR shifts in the address byte. At the eighth falling SCL it moves to ST_ADDR_ACK if the address matches a map, and to ST_SKIP if it does not.
- ST_ADDR_ACK drives the acknowledge. At the next falling SCL it moves to ST_RD for a read or to ST_WR for a write.
- ST_WR shifts in a data byte. At the eighth falling SCL it moves to ST_WR_ACK, and ST_WR_ACK returns to ST_WR at the next falling SCL.
- ST_RD drives a byte out, most significant bit first, and moves to ST_RD_ACK after eight bits. ST_RD_ACK samples the controller's acknowledge. On an acknowledge it goes back to ST_RD with the next byte, and on a not-acknowledge it goes to ST_SKIP.
- ST_SKIP keeps SDA released.

From any state, a START leads to ST_ADDR and a STOP leads to ST_IDLE.

Top module: `i2c_regmap_slave`

## Requirements
- R1: The main map is acknowledged at 7-bit address 0x39, which is 0x72 as an 8-bit write address with the read/write bit as the least significant bit.
- R2: Main registers 0x45, 0x43 and 0xE1 hold, in bits [7:1], the 7-bit addresses of map 1, map 2 and map 3. Their reset values are 0x70, 0x7E and 0x78, so the addresses after reset are 0x38, 0x3F and 0x3C. If two addresses are equal, the main map wins, then map 1, then map 2, then map 3.
- R3: A new value written to an address register takes effect at the next address phase. The old address is then no longer acknowledged. The contents of the map are kept.
- R4: An address that matches no map is not acknowledged. SDA stays released, including on the following bytes, until the next START.
- R5: The first byte written after the address byte loads the register pointer. Every further data byte, written or read, advances the pointer by one. The pointer is shared by all maps and is kept across STOP and repeated START.
- R6: The pointer wraps from 0xFF to 0x00.
- R7: Main register 0x42 reads the synchronized hot-plug level in bit 6 and 0 in every other bit. Writes to it have no effect.
- R8: A change of the hot-plug level sets flag bit 7 of main register 0x96. A high level on ev_i[k] sets flag bit k. A flag and irq_o become active on the same clock edge.
- R9: Writing 1 to a bit of main register 0x96 clears that flag, and writing 0 leaves it unchanged. irq_o is high while any flag is set whose enable bit in main register 0x94 is set. Register 0x94 resets to 0xFF.
- R10: While hot-plug is low, main registers 0x80 to 0x8F read 0x00 and ignore writes. While hot-plug is high they are ordinary read/write registers. They return to 0x00 when hot-plug goes low.
- R11: Main register 0x41 bit 6 is the power-down control. It resets to 1, so the register reads 0x40 after reset, and pwr_down_o follows the bit.
- R12: The four maps are independent 256-byte stores. The same offset in different maps holds separate data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| hpd_i | input | 1 | Hot-plug detect level |
| ev_i | input | EV_W | Interrupt event inputs, each sets its flag while high |
| irq_o | output | 1 | Active-high interrupt |
| pwr_down_o | output | 1 | Power-down control from main 0x41 bit 6 |

## Verification
A wrong bus state shows up within one bit time as an acknowledge that is missing or extra, or as a read bit driven at the wrong moment. The address sweep catches these on every one of the 128 addresses. A wrong pointer shows up on the first byte read back after a burst, because every map is filled with a computed pattern. Flag or protection errors show up at irq_o or in the next read of the flag register, or of the protected registers, after hot-plug or an event changes.

// File: rtl/i2c_rm_pkg.sv
`timescale 1ns/1ps
package i2c_rm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK, ST_SKIP
    } bus_st_e;

    localparam int NMAP = 4;
    typedef logic [1:0] map_id_t;

    localparam logic [6:0] MAIN_ADDR7   = 7'h39;
    localparam logic [7:0] REG_PWR      = 8'h41;
    localparam logic [7:0] REG_HPST     = 8'h42;
    localparam logic [7:0] REG_SINK_ADR = 8'h43;
    localparam logic [7:0] REG_PKT_ADR  = 8'h45;
    localparam logic [7:0] REG_MSG_ADR  = 8'hE1;
    localparam logic [7:0] REG_IEN      = 8'h94;
    localparam logic [7:0] REG_IFLG     = 8'h96;
endpackage

// File: rtl/i2c_rm_sync.sv
`timescale 1ns/1ps
module i2c_rm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic hpd_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_s,
    output logic start_det,
    output logic stop_det,
    output logic hpd_s
);
    logic [STAGES-1:0] scl_p, sda_p, hpd_p;
    logic scl_q, sda_q, scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= '1;
            sda_p <= '1;
            hpd_p <= '0;
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_p <= {scl_p[STAGES-2:0], scl_i};
            sda_p <= {sda_p[STAGES-2:0], sda_i};
            hpd_p <= {hpd_p[STAGES-2:0], hpd_i};
            scl_q <= scl_p[STAGES-1];
            sda_q <= sda_p[STAGES-1];
        end
    end

    assign scl_s     = scl_p[STAGES-1];
    assign sda_s     = sda_p[STAGES-1];
    assign hpd_s     = hpd_p[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_rm_fsm.sv
`timescale 1ns/1ps
module i2c_rm_fsm import i2c_rm_pkg::*; (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       sda_s,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic       addr_hit,
    input  map_id_t    hit_map,
    input  logic [7:0] rd_data,
    output bus_st_e    st,
    output logic [6:0] addr7,
    output map_id_t    map_sel,
    output logic       wr_stb,
    output logic       wr_is_ptr,
    output logic [7:0] wr_byte,
    output logic       rd_stb,
    output logic       sda_oe
);
    bus_st_e    st_q, st_d;
    logic [7:0] sh, tx;
    logic [3:0] cnt;
    logic       rw, first, nack;
    logic       byte_end;

    assign byte_end = scl_fall && (cnt == 4'd8);

    // next state
    always_comb begin
        st_d = st_q;
        if (start_det) st_d = ST_ADDR;
        else if (stop_det) st_d = ST_IDLE;
        else begin
            unique case (st_q)
                ST_IDLE:     ;
                ST_ADDR:     if (byte_end) st_d = addr_hit ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK: if (scl_fall) st_d = rw ? ST_RD : ST_WR;
                ST_WR:       if (byte_end) st_d = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) st_d = ST_WR;
                ST_RD:       if (byte_end) st_d = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall) st_d = nack ? ST_SKIP : ST_RD;
                ST_SKIP:     ;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // shift, count and byte registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh <= '0; tx <= '0; cnt <= '0;
            rw <= 1'b0; first <= 1'b0; nack <= 1'b0;
            map_sel <= '0;
        end else if (start_det) begin
            cnt <= '0;
        end else begin
            unique case (st_q)
                ST_ADDR: begin
                    if (scl_rise) begin sh <= {sh[6:0], sda_s}; cnt <= cnt + 4'd1; end
                    if (byte_end) begin map_sel <= hit_map; rw <= sh[0]; first <= 1'b1; end
                end
                ST_ADDR_ACK: if (scl_fall) begin cnt <= '0; if (rw) tx <= rd_data; end
                ST_WR: begin
                    if (scl_rise) begin sh <= {sh[6:0], sda_s}; cnt <= cnt + 4'd1; end
                    if (byte_end) first <= 1'b0;
                end
                ST_WR_ACK: if (scl_fall) cnt <= '0;
                ST_RD: begin
                    if (scl_rise) cnt <= cnt + 4'd1;
                    if (scl_fall && cnt != 4'd8) tx <= {tx[6:0], 1'b0};
                end
                ST_RD_ACK: begin
                    if (scl_rise) nack <= sda_s;
                    if (scl_fall) begin cnt <= '0; tx <= rd_data; end
                end
                ST_IDLE, ST_SKIP: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        st        = st_q;
        addr7     = sh[7:1];
        wr_byte   = sh;
        wr_is_ptr = first;
        wr_stb    = (st_q == ST_WR) && byte_end;
        rd_stb    = scl_fall && (((st_q == ST_ADDR_ACK) && rw) || ((st_q == ST_RD_ACK) && !nack));
        unique case (st_q)
            ST_ADDR_ACK, ST_WR_ACK: sda_oe = 1'b1;
            ST_RD:                  sda_oe = ~tx[7];
            default:                sda_oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/i2c_rm_regs.sv
`timescale 1ns/1ps
module i2c_rm_regs import i2c_rm_pkg::*; #(
    parameter int         EV_W    = 2,
    parameter logic [7:0] PROT_LO = 8'h80,
    parameter logic [7:0] PROT_HI = 8'h8F
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hpd_s,
    input  logic [EV_W-1:0] ev_i,
    input  logic [6:0]      addr7,
    input  map_id_t         map_sel,
    input  logic            wr_stb,
    input  logic            wr_is_ptr,
    input  logic [7:0]      wr_byte,
    input  logic            rd_stb,
    output logic            addr_hit,
    output map_id_t         hit_map,
    output logic [7:0]      rd_data,
    output logic [7:0]      ptr,
    output logic [7:0]      flags,
    output logic [7:0]      ien,
    output logic            irq_o,
    output logic            pwr_down_o
);
    localparam int DEPTH = 256;

    logic [7:0] mem [NMAP][DEPTH];
    logic [7:0] ptr_q, flags_q, set_v, clr_v;
    logic       hpd_q, is_main, prot_hit, writable;

    function automatic logic [7:0] dflt(input int m, input int a);
        if (m != 0) return 8'h00;
        case (a)
            int'(REG_PWR):      return 8'h40;
            int'(REG_SINK_ADR): return 8'h7E;
            int'(REG_PKT_ADR):  return 8'h70;
            int'(REG_MSG_ADR):  return 8'h78;
            int'(REG_IEN):      return 8'hFF;
            default:            return 8'h00;
        endcase
    endfunction

    assign is_main  = (map_sel == 2'd0);
    assign prot_hit = is_main && (ptr_q >= PROT_LO) && (ptr_q <= PROT_HI);
    assign writable = !(is_main && (ptr_q == REG_HPST || ptr_q == REG_IFLG)) && !(prot_hit && !hpd_s);

    always_comb begin
        set_v          = '0;
        set_v[7]       = hpd_s ^ hpd_q;
        set_v[EV_W-1:0] = ev_i;
        clr_v = (wr_stb && !wr_is_ptr && is_main && ptr_q == REG_IFLG) ? wr_byte : 8'h00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int m = 0; m < NMAP; m++)
                for (int a = 0; a < DEPTH; a++)
                    mem[m[1:0]][a[7:0]] <= dflt(m, a);
            ptr_q   <= '0;
            flags_q <= '0;
            hpd_q   <= 1'b0;
        end else begin
            hpd_q   <= hpd_s;
            flags_q <= (flags_q & ~clr_v) | set_v;
            if (wr_stb) begin
                if (wr_is_ptr) ptr_q <= wr_byte;
                else begin
                    ptr_q <= ptr_q + 8'd1;
                    if (writable) mem[map_sel][ptr_q] <= wr_byte;
                end
            end else if (rd_stb) begin
                ptr_q <= ptr_q + 8'd1;
            end
            if (!hpd_s)
                for (int a = int'(PROT_LO); a <= int'(PROT_HI); a++)
                    mem[0][a[7:0]] <= dflt(0, a);
        end
    end

    always_comb begin
        addr_hit = 1'b1;
        hit_map  = 2'd0;
        if (addr7 == MAIN_ADDR7)                 hit_map = 2'd0;
        else if (addr7 == mem[0][REG_PKT_ADR][7:1])  hit_map = 2'd1;
        else if (addr7 == mem[0][REG_SINK_ADR][7:1]) hit_map = 2'd2;
        else if (addr7 == mem[0][REG_MSG_ADR][7:1])  hit_map = 2'd3;
        else addr_hit = 1'b0;
    end

    always_comb begin
        if (is_main && ptr_q == REG_HPST)      rd_data = {1'b0, hpd_s, 6'b0};
        else if (is_main && ptr_q == REG_IFLG) rd_data = flags_q;
        else                                   rd_data = mem[map_sel][ptr_q];
    end

    assign ptr        = ptr_q;
    assign flags      = flags_q;
    assign ien        = mem[0][REG_IEN];
    assign irq_o      = |(flags_q & mem[0][REG_IEN]);
    assign pwr_down_o = mem[0][REG_PWR][6];
endmodule

// File: rtl/i2c_regmap_slave.sv
`timescale 1ns/1ps
module i2c_regmap_slave import i2c_rm_pkg::*; #(
    parameter int         EV_W        = 2,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] PROT_LO     = 8'h80,
    parameter logic [7:0] PROT_HI     = 8'h8F
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_i,
    input  logic            sda_i,
    output logic            sda_oe_o,
    input  logic            hpd_i,
    input  logic [EV_W-1:0] ev_i,
    output logic            irq_o,
    output logic            pwr_down_o
);
    logic       scl_rise, scl_fall, sda_s, start_det, stop_det, hpd_s;
    logic       addr_hit, wr_stb, wr_is_ptr, rd_stb;
    map_id_t    hit_map, map_sel;
    logic [6:0] addr7;
    logic [7:0] rd_data, wr_byte, ptr, flags, ien;
    bus_st_e    st;

    i2c_rm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .hpd_i(hpd_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
        .start_det(start_det), .stop_det(stop_det), .hpd_s(hpd_s)
    );

    i2c_rm_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det),
        .addr_hit(addr_hit), .hit_map(hit_map), .rd_data(rd_data),
        .st(st), .addr7(addr7), .map_sel(map_sel), .wr_stb(wr_stb),
        .wr_is_ptr(wr_is_ptr), .wr_byte(wr_byte), .rd_stb(rd_stb), .sda_oe(sda_oe_o)
    );

    i2c_rm_regs #(.EV_W(EV_W), .PROT_LO(PROT_LO), .PROT_HI(PROT_HI)) u_regs (
        .clk(clk), .rst_n(rst_n), .hpd_s(hpd_s), .ev_i(ev_i), .addr7(addr7),
        .map_sel(map_sel), .wr_stb(wr_stb), .wr_is_ptr(wr_is_ptr), .wr_byte(wr_byte),
        .rd_stb(rd_stb), .addr_hit(addr_hit), .hit_map(hit_map), .rd_data(rd_data),
        .ptr(ptr), .flags(flags), .ien(ien), .irq_o(irq_o), .pwr_down_o(pwr_down_o)
    );
endmodule

// File: rtl/i2c_rm_chk.sv
`timescale 1ns/1ps
module i2c_rm_chk import i2c_rm_pkg::*; (
    input logic       clk,
    input logic       rst_n,
    input bus_st_e    st,
    input logic       sda_oe,
    input logic       wr_stb,
    input logic       wr_is_ptr,
    input logic [7:0] wr_byte,
    input logic       rd_stb,
    input logic [7:0] ptr,
    input logic [7:0] flags,
    input logic [7:0] ien,
    input logic       irq
);
    // R4
    sda_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (st == ST_ADDR_ACK || st == ST_WR_ACK || st == ST_RD));

    // R5
    ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_is_ptr) |=> (ptr == $past(wr_byte)));

    // R5
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_stb && !wr_is_ptr) || rd_stb) |=> (ptr == $past(ptr) + 8'd1));

    // R8
    flag_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flags[7]) && ien[7]) |-> irq);

    // R9
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq) && !irq) |-> $past(wr_stb));
endmodule

bind i2c_regmap_slave i2c_rm_chk u_chk (
    .clk(clk), .rst_n(rst_n), .st(st), .sda_oe(sda_oe_o), .wr_stb(wr_stb),
    .wr_is_ptr(wr_is_ptr), .wr_byte(wr_byte), .rd_stb(rd_stb), .ptr(ptr),
    .flags(flags), .ien(ien), .irq(irq_o)
);

// File: tb/sim_i2c_regmap_slave.sv
`timescale 1ns/1ps
module sim_i2c_regmap_slave;
    localparam int Q = 50;

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1, hpd = 1'b0;
    logic [1:0] ev = 2'b00;
    logic sda_oe, irq, pwr_dn, sda_bus;
    int vec = 0, miss = 0;
    bit done = 0;
    logic [7:0] wbuf [0:31];
    logic [7:0] rbuf [0:31];

    always #5 clk = ~clk;
    assign sda_bus = sda_m & ~sda_oe;

    i2c_regmap_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
        .hpd_i(hpd), .ev_i(ev), .irq_o(irq), .pwr_down_o(pwr_dn)
    );

    function automatic logic [7:0] pat(input int s, input int i);
        return 8'(s * 37 + i * 13 + 1);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        vec++;
        if (act !== exp) begin
            miss++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; #Q; scl_m = 1'b1; #(2*Q); scl_m = 1'b0; #Q;
    endtask

    task automatic bit_in(output logic b);
        sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; b = sda_bus; #Q; scl_m = 1'b0; #Q;
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; sda_m = 1'b0; #Q; scl_m = 1'b0; #Q;
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; #Q; scl_m = 1'b1; #Q; sda_m = 1'b1; #Q;
    endtask

    task automatic send(input logic [7:0] b, output bit ack);
        logic x;
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(x);
        ack = !x;
    endtask

    task automatic recv(input bit last, output logic [7:0] d);
        logic x;
        for (int i = 7; i >= 0; i--) begin bit_in(x); d[i] = x; end
        bit_out(last);
    endtask

    task automatic i2c_wr(input logic [6:0] dev, input logic [7:0] p, input int n, output bit ok);
        bit a;
        i2c_start();
        send({dev, 1'b0}, ok);
        send(p, a);
        for (int i = 0; i < n; i++) send(wbuf[i], a);
        i2c_stop();
    endtask

    task automatic i2c_rd(input logic [6:0] dev, input logic [7:0] p, input int n);
        bit a;
        i2c_start();
        send({dev, 1'b0}, a);
        send(p, a);
        i2c_start();
        send({dev, 1'b1}, a);
        for (int i = 0; i < n; i++) recv(i == n - 1, rbuf[i]);
        i2c_stop();
    endtask

    task automatic wr1(input logic [6:0] dev, input logic [7:0] p, input logic [7:0] v);
        bit ok;
        wbuf[0] = v;
        i2c_wr(dev, p, 1, ok);
    endtask

    task automatic rd1(input logic [6:0] dev, input logic [7:0] p, output logic [7:0] v);
        i2c_rd(dev, p, 1);
        v = rbuf[0];
    endtask

    initial begin
        #2000000;
        if (!done) begin
            miss++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        bit ok;
        #100 rst_n = 1'b1;
        #100;
        // reset state
        check("R11 pwr_down_o at reset", pwr_dn, 1);
        check("R9 irq_o at reset", irq, 0);
        check("R4 sda released at reset", sda_oe, 0);

        // R2 default address registers, R11 power register
        rd1(7'h39, 8'h43, v); check("R2 sink addr reg", v, 8'h7E);
        rd1(7'h39, 8'h45, v); check("R2 packet addr reg", v, 8'h70);
        rd1(7'h39, 8'hE1, v); check("R2 msg addr reg", v, 8'h78);
        rd1(7'h39, 8'h41, v); check("R11 power reg", v, 8'h40);

        // R1 / R4 sweep over all 7-bit addresses
        for (int a = 0; a < 128; a++) begin
            int exp;
            i2c_start();
            send({7'(a), 1'b0}, ok);
            i2c_stop();
            exp = (a == 'h39 || a == 'h38 || a == 'h3F || a == 'h3C) ? 1 : 0;
            check(a == 'h39 ? "R1 main ack" : "R4 address sweep ack", ok, exp);
        end

        // R7 hot-plug status, R8 flag
        rd1(7'h39, 8'h42, v); check("R7 hpd low status", v, 8'h00);
        check("R8 irq idle", irq, 0);
        hpd = 1'b1; #100;
        check("R8 irq on hpd change", irq, 1);
        rd1(7'h39, 8'h96, v); check("R8 hpd flag", v, 8'h80);
        rd1(7'h39, 8'h42, v); check("R7 hpd high status", v, 8'h40);
        wr1(7'h39, 8'h42, 8'hFF);
        rd1(7'h39, 8'h42, v); check("R7 write ignored", v, 8'h40);

        // R8 event input, R9 write-one-to-clear
        #10 ev = 2'b01; #10 ev = 2'b00; #20;
        rd1(7'h39, 8'h96, v); check("R8 event flag", v, 8'h81);
        wr1(7'h39, 8'h96, 8'h80);
        rd1(7'h39, 8'h96, v); check("R9 partial clear", v, 8'h01);
        check("R9 irq held", irq, 1);
        wr1(7'h39, 8'h96, 8'h00);
        rd1(7'h39, 8'h96, v); check("R9 zero write keeps", v, 8'h01);
        wr1(7'h39, 8'h94, 8'h80);
        check("R9 masked flag", irq, 0);
        wr1(7'h39, 8'h94, 8'hFF);
        check("R9 unmasked flag", irq, 1);
        wr1(7'h39, 8'h96, 8'h01);
        check("R9 all clear", irq, 0);

        // R10 protected range with hot-plug high, then low
        for (int i = 0; i < 18; i++) wbuf[i] = pat(5, i);
        i2c_wr(7'h39, 8'h7F, 18, ok);
        i2c_rd(7'h39, 8'h7F, 18);
        for (int i = 0; i < 18; i++) check("R10 writable while hpd high", rbuf[i], pat(5, i));
        hpd = 1'b0; #100;
        i2c_rd(7'h39, 8'h7F, 18);
        for (int i = 1; i < 17; i++) check("R10 cleared on hpd low", rbuf[i], 0);
        for (int i = 0; i < 18; i++) wbuf[i] = pat(6, i);
        i2c_wr(7'h39, 8'h7F, 18, ok);
        i2c_rd(7'h39, 8'h7F, 18);
        for (int i = 0; i < 18; i++)
            check("R10 write while hpd low", rbuf[i], (i == 0 || i == 17) ? pat(6, i) : 0);
        wr1(7'h39, 8'h96, 8'hFF);

        // R11 power-up
        wr1(7'h39, 8'h41, 8'h00);
        check("R11 pwr_down_o cleared", pwr_dn, 0);

        // R5 R6 R12 bursts in every map
        for (int m = 0; m < 4; m++) begin
            logic [6:0] dev;
            logic [7:0] base;
            dev  = (m == 0) ? 7'h39 : (m == 1) ? 7'h38 : (m == 2) ? 7'h3F : 7'h3C;
            base = (m == 0) ? 8'h20 : 8'hF4;
            for (int i = 0; i < 24; i++) wbuf[i] = pat(m + 10, i);
            i2c_wr(dev, base, 24, ok);
        end
        for (int m = 0; m < 4; m++) begin
            logic [6:0] dev;
            logic [7:0] base;
            dev  = (m == 0) ? 7'h39 : (m == 1) ? 7'h38 : (m == 2) ? 7'h3F : 7'h3C;
            base = (m == 0) ? 8'h20 : 8'hF4;
            i2c_rd(dev, base, 23);
            for (int i = 0; i < 23; i++)
                check(m == 0 ? "R5 burst readback" : "R6 wrap and R12 map data", rbuf[i], pat(m + 10, i));
            i2c_start();
            send({dev, 1'b1}, ok);
            recv(1'b1, v);
            i2c_stop();
            check("R5 pointer kept across transactions", v, pat(m + 10, 23));
        end

        // R3 move packet and sink addresses
        wr1(7'h39, 8'h45, 8'h50);
        wr1(7'h39, 8'h43, 8'h60);
        i2c_start(); send({7'h28, 1'b0}, ok); i2c_stop();
        check("R3 new packet address acked", ok, 1);
        i2c_start(); send({7'h30, 1'b0}, ok); i2c_stop();
        check("R3 new sink address acked", ok, 1);
        i2c_rd(7'h28, 8'hF4, 1);
        check("R3 packet data kept", rbuf[0], pat(11, 0));

        // R4 old address ignored for the whole transfer
        i2c_start();
        send({7'h38, 1'b0}, ok); check("R3 old address not acked", ok, 0);
        send(8'hF4, ok); check("R4 data byte not acked", ok, 0);
        send(8'h00, ok); check("R4 second byte not acked", ok, 0);
        i2c_stop();
        i2c_rd(7'h28, 8'hF4, 1);
        check("R4 ignored write left data", rbuf[0], pat(11, 0));

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
        $finish;
    end
endmodule